// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the per-processor timer of a local interrupt controller. Software programs three things through a small write port: a timer control word, which holds the interrupt vector, a mask bit and a periodic/one-shot mode bit; an initial count; and a divide setting that becomes a power-of-two prescale shift. The block never decrements a counter. When the initial count is written, it records the current value of a free-running time base as the load time. From then on it describes the timer by one absolute time: the time base value at which the next expiry falls.

Every write to the count or to the control word recomputes that expiry. The current elapsed tick count is the time since load, shifted right by the prescale. The rule for placing the next expiry depends on the mode. When the time base reaches or passes the armed expiry, the block raises a one-cycle interrupt request carrying the programmed vector. A one-shot timer then disarms. A periodic timer advances its expiry by one period. A write in the same cycle as a due expiry takes precedence, and the pulse follows one cycle later if the timer is still due. Prioritisation and delivery of the request belong to the surrounding interrupt logic.

Top module: `local_timer`

## Requirements
- R1: When a write to the control word (select 0) sets the mask bit (bit 16), the timer is disarmed: `expiry_valid_o` is 0 and `expiry_time_o` reads all ones, which is the marker for no armed expiry. No interrupt pulse follows.
- R2: A write to select 2 stores divide bits [3:0]. It sets the prescale shift to (({b3,b1,b0}) + 1) mod 8, so 4'b1011 gives shift 0, 4'b0000 gives 1, 4'b0001 gives 2 and 4'b1000 gives 5. Bit 2 is ignored. This write leaves the load time and the armed expiry unchanged.
- R3: Elapsed ticks equal (time base minus load time) shifted right by the prescale shift. Every recomputation uses this value.
- R4: In periodic mode (control bit 17 set), an initial count of zero arms no expiry.
- R5: In periodic mode the period is count+1 ticks. The expiry is load time plus (the smallest multiple of the period that exceeds the elapsed ticks) shifted left by the prescale shift.
- R6: In one-shot mode (bit 17 clear), if the elapsed ticks are at least the count, nothing is armed. Otherwise the expiry is load time plus ((count+1) shifted left by the prescale shift).
- R7: A write to select 1 stores the count from the low data bits and captures the time base as the load time. Both a count write and a control write recompute the expiry, with the new values visible the cycle after the write.
- R8: At the first clock edge where the time base equals or exceeds the armed expiry, `irq_o` is high for the following cycle with `irq_vector_o` equal to control bits [7:0]. A one-shot timer is then disarmed.
- R9: After each pulse, a periodic timer adds (count+1) shifted by the prescale to its expiry. If the time base is already far past the expiry, it fires once per cycle until the expiry is ahead of the time base again.
- R10: After reset, the control word reads 0x0001_0000 (masked), and the divide setting, shift, count and load time are 0. The timer is unarmed, with an all-ones expiry, and `irq_o` is 0.
- R11: A write with select 3 changes no register and no expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 count, 2 divide, 3 none |
| wr_data | input | DW | Write data |
| now | input | TW | Free-running time base |
| tmr_ctrl_o | output | DW | Control word readback |
| divide_cfg_o | output | 4 | Divide setting readback |
| prescale_shift_o | output | 3 | Current prescale shift |
| initial_count_o | output | CW | Initial count readback |
| load_time_o | output | TW | Time base value captured at the last count write |
| expiry_valid_o | output | 1 | An expiry is armed |
| expiry_time_o | output | TW | Absolute expiry time, all ones when unarmed |
| irq_o | output | 1 | One-cycle interrupt request |
| irq_vector_o | output | VW | Vector carried with the request |

## Verification
The bench builds the timer with a 32-bit time base, a 16-bit count, 32-bit write data and an 8-bit vector. With these values, its reference arithmetic fits in plain 32-bit variables, and the small counts and shifts it programs put every expiry within a few dozen cycles. The bench drives the time base directly rather than from the clock. This lets it write a control word at an exact tick offset, to probe the one-shot boundary where elapsed ticks equal the count. It also lets it jump the time far past an armed periodic expiry, which brings the once-per-cycle catch-up within reach.

// File: rtl/lt_pkg.sv
`timescale 1ns/1ps
package lt_pkg;

  // Write targets of the register port.
  typedef enum logic [1:0] {
    SEL_VECTOR = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_DIVIDE = 2'd2,
    SEL_NONE   = 2'd3
  } lt_sel_e;

  // Control word bit positions: the bench and software decode these.
  localparam int VEC_MASK_BIT = 16;
  localparam int VEC_MODE_BIT = 17;
  localparam int SHIFT_W      = 3;

  // Divide setting to prescale shift: bits 3,1,0 form a code and the
  // shift is one more, wrapping so that the all-ones code means x1.
  function automatic logic [SHIFT_W-1:0] divide_to_shift(input logic [3:0] cfg);
    logic [SHIFT_W-1:0] code;
    code = {cfg[3], cfg[1], cfg[0]};
    return code + SHIFT_W'(1);
  endfunction

endpackage

// File: rtl/lt_regs.sv
`timescale 1ns/1ps
module lt_regs
  import lt_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 32,
  parameter int TW = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [DW-1:0]      wr_data,
  input  logic [TW-1:0]      now,
  output logic [DW-1:0]      ctrl_q,
  output logic [3:0]         div_cfg_q,
  output logic [SHIFT_W-1:0] shift_q,
  output logic [CW-1:0]      count_q,
  output logic [TW-1:0]      load_q,
  output logic               masked_nx,
  output logic               periodic_nx,
  output logic [SHIFT_W-1:0] shift_nx,
  output logic [CW-1:0]      count_nx,
  output logic [TW-1:0]      load_nx,
  output logic               recalc,
  output logic               div_wr
);
  localparam logic [DW-1:0] CTRL_RST = DW'(1) << VEC_MASK_BIT;

  lt_sel_e       sel;
  logic [DW-1:0] ctrl_nx;
  logic [3:0]    div_cfg_nx;

  assign sel    = lt_sel_e'(wr_sel);
  assign recalc = wr_en && ((sel == SEL_VECTOR) || (sel == SEL_COUNT));
  assign div_wr = wr_en && (sel == SEL_DIVIDE);

  always_comb begin
    ctrl_nx    = ctrl_q;
    div_cfg_nx = div_cfg_q;
    shift_nx   = shift_q;
    count_nx   = count_q;
    load_nx    = load_q;
    if (wr_en) begin
      case (sel)
        SEL_VECTOR: ctrl_nx = wr_data;
        SEL_COUNT: begin
          count_nx = wr_data[CW-1:0];
          load_nx  = now;
        end
        SEL_DIVIDE: begin
          div_cfg_nx = wr_data[3:0];
          shift_nx   = divide_to_shift(wr_data[3:0]);
        end
        default: ;
      endcase
    end
  end

  assign masked_nx   = ctrl_nx[VEC_MASK_BIT];
  assign periodic_nx = ctrl_nx[VEC_MODE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= CTRL_RST;
      div_cfg_q <= '0;
      shift_q   <= '0;
      count_q   <= '0;
      load_q    <= '0;
    end else begin
      ctrl_q    <= ctrl_nx;
      div_cfg_q <= div_cfg_nx;
      shift_q   <= shift_nx;
      count_q   <= count_nx;
      load_q    <= load_nx;
    end
  end

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_COUNT) |=> (load_q == $past(now))); // R7

  AST_DIV_KEEPS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> ($stable(load_q) && $stable(count_q) && $stable(ctrl_q))); // R2

  AST_SEL_NONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_NONE) |=> ($stable(ctrl_q) && $stable(count_q) &&
      $stable(load_q) && $stable(shift_q) && $stable(div_cfg_q))); // R11

endmodule

// File: rtl/lt_calc.sv
`timescale 1ns/1ps
module lt_calc
  import lt_pkg::*;
#(
  parameter int CW = 32,
  parameter int TW = 48
) (
  input  logic               masked,
  input  logic               periodic,
  input  logic [CW-1:0]      count,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [TW-1:0]      load,
  input  logic [TW-1:0]      now,
  output logic               arm,
  output logic [TW-1:0]      when
);
  // Ticks since the load time at the current prescale.
  function automatic logic [TW-1:0] span_ticks(input logic [TW-1:0] t,
                                               input logic [TW-1:0] base,
                                               input logic [SHIFT_W-1:0] sh);
    return (t - base) >> sh;
  endfunction

  function automatic logic [TW-1:0] period_len(input logic [CW-1:0] c);
    return TW'(c) + TW'(1);
  endfunction

  // First whole multiple of the period strictly beyond the elapsed ticks.
  function automatic logic [TW-1:0] periodic_target(input logic [TW-1:0] ticks,
                                                    input logic [TW-1:0] per);
    logic [TW-1:0] q;
    q = ticks / per;
    return (q + TW'(1)) * per;
  endfunction

  logic [TW-1:0] ticks;
  logic [TW-1:0] per;
  logic [TW-1:0] target;

  assign ticks  = span_ticks(now, load, shift);
  assign per    = period_len(count);
  assign target = periodic ? periodic_target(ticks, per) : per;
  assign when   = load + (target << shift);

  always_comb begin
    if (masked)
      arm = 1'b0;
    else if (periodic)
      arm = (count != '0);
    else
      arm = (ticks < TW'(count));
  end

endmodule

// File: rtl/lt_arm.sv
`timescale 1ns/1ps
module lt_arm #(
  parameter int TW = 48,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          recalc,
  input  logic          hold,
  input  logic          calc_arm,
  input  logic [TW-1:0] calc_when,
  input  logic [TW-1:0] now,
  input  logic          periodic,
  input  logic [TW-1:0] step,
  input  logic [VW-1:0] vector,
  output logic          valid_o,
  output logic [TW-1:0] expiry_o,
  output logic          irq_o,
  output logic [VW-1:0] irq_vec_o
);
  logic due;
  logic fire;

  assign due  = valid_o && (now >= expiry_o);
  assign fire = due && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o   <= 1'b0;
      expiry_o  <= '1;
      irq_o     <= 1'b0;
      irq_vec_o <= '0;
    end else begin
      irq_o <= fire;
      if (fire) irq_vec_o <= vector;
      if (recalc) begin
        valid_o  <= calc_arm;
        expiry_o <= calc_arm ? calc_when : '1;
      end else if (fire) begin
        if (periodic) begin
          expiry_o <= expiry_o + step;
        end else begin
          valid_o  <= 1'b0;
          expiry_o <= '1;
        end
      end
    end
  end

  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !periodic) |=> !valid_o); // R8

  AST_PERIODIC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && periodic) |=> (valid_o && expiry_o == $past(expiry_o) + $past(step))); // R9

  AST_IRQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(valid_o)); // R8

  AST_UNARMED_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (&expiry_o)); // R1

endmodule

// File: rtl/local_timer.sv
`timescale 1ns/1ps
module local_timer
  import lt_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 32,
  parameter int TW = 48,
  parameter int VW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [DW-1:0]      wr_data,
  input  logic [TW-1:0]      now,
  output logic [DW-1:0]      tmr_ctrl_o,
  output logic [3:0]         divide_cfg_o,
  output logic [SHIFT_W-1:0] prescale_shift_o,
  output logic [CW-1:0]      initial_count_o,
  output logic [TW-1:0]      load_time_o,
  output logic               expiry_valid_o,
  output logic [TW-1:0]      expiry_time_o,
  output logic               irq_o,
  output logic [VW-1:0]      irq_vector_o
);
  logic               masked_nx, periodic_nx;
  logic [SHIFT_W-1:0] shift_nx;
  logic [CW-1:0]      count_nx;
  logic [TW-1:0]      load_nx;
  logic               recalc, div_wr;
  logic               calc_arm;
  logic [TW-1:0]      calc_when;
  logic [TW-1:0]      period_step;

  lt_regs #(.DW(DW), .CW(CW), .TW(TW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .now(now),
    .ctrl_q(tmr_ctrl_o), .div_cfg_q(divide_cfg_o), .shift_q(prescale_shift_o),
    .count_q(initial_count_o), .load_q(load_time_o),
    .masked_nx(masked_nx), .periodic_nx(periodic_nx), .shift_nx(shift_nx),
    .count_nx(count_nx), .load_nx(load_nx),
    .recalc(recalc), .div_wr(div_wr)
  );

  lt_calc #(.CW(CW), .TW(TW)) u_calc (
    .masked(masked_nx), .periodic(periodic_nx), .count(count_nx),
    .shift(shift_nx), .load(load_nx), .now(now),
    .arm(calc_arm), .when(calc_when)
  );

  assign period_step = (TW'(initial_count_o) + TW'(1)) << prescale_shift_o;

  lt_arm #(.TW(TW), .VW(VW)) u_arm (
    .clk(clk), .rst_n(rst_n), .recalc(recalc), .hold(wr_en),
    .calc_arm(calc_arm), .calc_when(calc_when), .now(now),
    .periodic(tmr_ctrl_o[VEC_MODE_BIT]), .step(period_step),
    .vector(tmr_ctrl_o[VW-1:0]),
    .valid_o(expiry_valid_o), .expiry_o(expiry_time_o),
    .irq_o(irq_o), .irq_vec_o(irq_vector_o)
  );

  AST_MASK_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_VECTOR && wr_data[VEC_MASK_BIT]) |=> !expiry_valid_o); // R1

  AST_DIV_KEEPS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> ($stable(expiry_time_o) && $stable(expiry_valid_o))); // R2

  AST_PERIODIC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (recalc && periodic_nx && count_nx == '0) |=> !expiry_valid_o); // R4

endmodule

// File: tb/local_timer_bench.sv
`timescale 1ns/1ps
module local_timer_bench;
  localparam int DW = 32;
  localparam int CW = 16;
  localparam int TW = 32;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic [DW-1:0] wr_data = '0;
  logic [TW-1:0] tb_now = '0;
  logic [DW-1:0] tmr_ctrl_o;
  logic [3:0]    divide_cfg_o;
  logic [2:0]    prescale_shift_o;
  logic [CW-1:0] initial_count_o;
  logic [TW-1:0] load_time_o;
  logic          expiry_valid_o;
  logic [TW-1:0] expiry_time_o;
  logic          irq_o;
  logic [VW-1:0] irq_vector_o;

  int n_chk = 0;
  int n_err = 0;
  int n_fire = 0;
  logic [31:0] fire_t [0:15];
  logic [7:0]  fire_v = '0;
  logic [31:0] last_wr = '0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  local_timer #(.DW(DW), .CW(CW), .TW(TW), .VW(VW)) u_local_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .now(tb_now), .tmr_ctrl_o(tmr_ctrl_o), .divide_cfg_o(divide_cfg_o),
    .prescale_shift_o(prescale_shift_o), .initial_count_o(initial_count_o),
    .load_time_o(load_time_o), .expiry_valid_o(expiry_valid_o),
    .expiry_time_o(expiry_time_o), .irq_o(irq_o), .irq_vector_o(irq_vector_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One clock: sample the pulse seen after the last edge, advance time.
  task automatic cyc();
    @(negedge clk);
    if (irq_o === 1'b1) begin
      if (n_fire < 16) fire_t[n_fire] = tb_now;
      fire_v = irq_vector_o;
      n_fire++;
    end
    tb_now = tb_now + 1;
    wr_en  = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d; last_wr = tb_now;
    cyc();
  endtask

  function automatic logic [31:0] vreg(input bit m, input bit p, input logic [7:0] v);
    return (32'(m) << 16) | (32'(p) << 17) | 32'(v);
  endfunction

  // Periodic reference: walk multiples of the period past the elapsed ticks.
  function automatic logic [31:0] mdl_periodic(input logic [31:0] ld, input logic [31:0] t,
                                               input logic [31:0] c, input int s);
    logic [31:0] ticks, per, m;
    ticks = (t - ld) >> s;
    per = c + 1;
    m = per;
    while (m <= ticks) m = m + per;
    return ld + (m << s);
  endfunction

  task automatic t_reset();
    chk("R10 ctrl", 64'(tmr_ctrl_o), 64'h0001_0000);
    chk("R10 divide", 64'(divide_cfg_o), 0);
    chk("R10 shift", 64'(prescale_shift_o), 0);
    chk("R10 count", 64'(initial_count_o), 0);
    chk("R10 load", 64'(load_time_o), 0);
    chk("R10 valid", 64'(expiry_valid_o), 0);
    chk("R10 expiry", 64'(expiry_time_o), 64'hFFFF_FFFF);
    chk("R10 irq", 64'(irq_o), 0);
  endtask

  task automatic t_oneshot();
    logic [31:0] ld;
    wr(2'd2, 32'hB);
    chk("R2 shift code 1011", 64'(prescale_shift_o), 0);
    wr(2'd0, vreg(0, 0, 8'h31));
    chk("R6 count zero unarmed", 64'(expiry_valid_o), 0);
    wr(2'd1, 32'd10); ld = last_wr;
    chk("R7 load captured", 64'(load_time_o), 64'(ld));
    chk("R6 armed", 64'(expiry_valid_o), 1);
    chk("R6 expiry", 64'(expiry_time_o), 64'(ld + 11));
    n_fire = 0;
    repeat (30) cyc();
    chk("R8 one pulse", 64'(n_fire), 1);
    chk("R8 fire time", 64'(fire_t[0]), 64'(ld + 11));
    chk("R8 vector", 64'(fire_v), 64'h31);
    chk("R8 disarmed", 64'(expiry_valid_o), 0);
    chk("R1 unarmed marker", 64'(expiry_time_o), 64'hFFFF_FFFF);
  endtask

  task automatic t_divide();
    logic [31:0] ld;
    wr(2'd2, 32'h1);
    chk("R2 shift code 0001", 64'(prescale_shift_o), 2);
    wr(2'd1, 32'd5); ld = last_wr;
    chk("R6 scaled expiry", 64'(expiry_time_o), 64'(ld + 24));
    wr(2'd2, 32'h8);
    chk("R2 shift code 1000", 64'(prescale_shift_o), 5);
    chk("R2 divide readback", 64'(divide_cfg_o), 8);
    chk("R2 expiry kept", 64'(expiry_time_o), 64'(ld + 24));
    chk("R2 load kept", 64'(load_time_o), 64'(ld));
    wr(2'd2, 32'h6);
    chk("R2 bit2 ignored", 64'(prescale_shift_o), 3);
    wr(2'd2, 32'hA);
    chk("R2 shift code 1010", 64'(prescale_shift_o), 7);
    wr(2'd2, 32'h1);
    n_fire = 0;
    repeat (40) cyc();
    chk("R8 scaled pulse count", 64'(n_fire), 1);
    chk("R8 scaled fire time", 64'(fire_t[0]), 64'(ld + 24));
  endtask

  task automatic t_periodic();
    logic [31:0] ld;
    wr(2'd2, 32'h0);
    ld = load_time_o;
    wr(2'd0, vreg(0, 1, 8'h42));
    chk("R5 recompute on control write", 64'(expiry_time_o),
        64'(mdl_periodic(ld, last_wr, 5, 1)));
    wr(2'd1, 32'd3); ld = last_wr;
    chk("R5 first expiry", 64'(expiry_time_o), 64'(ld + 8));
    n_fire = 0;
    repeat (26) cyc();
    chk("R9 pulse count", 64'(n_fire), 3);
    chk("R9 first", 64'(fire_t[0]), 64'(ld + 8));
    chk("R9 second", 64'(fire_t[1]), 64'(ld + 16));
    chk("R9 third", 64'(fire_t[2]), 64'(ld + 24));
    chk("R8 periodic vector", 64'(fire_v), 64'h42);
    chk("R9 next expiry", 64'(expiry_time_o), 64'(ld + 32));
    wr(2'd1, 32'd0);
    chk("R4 zero count unarmed", 64'(expiry_valid_o), 0);
    n_fire = 0;
    repeat (20) cyc();
    chk("R4 no pulse", 64'(n_fire), 0);
  endtask

  task automatic t_midway();
    logic [31:0] ld;
    wr(2'd1, 32'd4); ld = last_wr;
    repeat (22) cyc();
    wr(2'd0, vreg(0, 1, 8'h55));
    chk("R3 elapsed periodic", 64'(expiry_time_o), 64'(mdl_periodic(ld, last_wr, 4, 1)));
    chk("R3 expected value", 64'(expiry_time_o), 64'(ld + 30));
    wr(2'd2, 32'hB);
    wr(2'd1, 32'd20); ld = last_wr;
    repeat (6) cyc();
    wr(2'd0, vreg(0, 0, 8'h56));
    chk("R6 one-shot mid write", 64'(expiry_time_o), 64'(ld + 21));
    n_fire = 0;
    repeat (20) cyc();
    chk("R6 one-shot pulse", 64'(n_fire), 1);
    wr(2'd0, vreg(0, 0, 8'h57));
    chk("R6 past count unarmed", 64'(expiry_valid_o), 0);
    wr(2'd1, 32'd20); ld = last_wr;
    n_fire = 0;
    repeat (19) cyc();
    wr(2'd0, vreg(0, 0, 8'h58));
    chk("R3 boundary tick offset", 64'(last_wr - ld), 20);
    chk("R6 ticks equal count unarmed", 64'(expiry_valid_o), 0);
    chk("R6 boundary no pulse", 64'(n_fire), 0);
  endtask

  task automatic t_mask();
    wr(2'd0, vreg(0, 1, 8'h60));
    wr(2'd1, 32'd2);
    chk("R1 armed before mask", 64'(expiry_valid_o), 1);
    wr(2'd0, vreg(1, 1, 8'h60));
    chk("R1 masked unarmed", 64'(expiry_valid_o), 0);
    chk("R1 masked marker", 64'(expiry_time_o), 64'hFFFF_FFFF);
    n_fire = 0;
    repeat (30) cyc();
    chk("R1 masked no pulse", 64'(n_fire), 0);
  endtask

  task automatic t_catchup();
    logic [31:0] ld;
    wr(2'd0, vreg(0, 1, 8'h70));
    wr(2'd1, 32'd1); ld = last_wr;
    tb_now = ld + 9;
    n_fire = 0;
    repeat (9) cyc();
    chk("R9 catch-up count", 64'(n_fire), 8);
    chk("R9 catch-up first", 64'(fire_t[0]), 64'(ld + 9));
    chk("R9 catch-up last", 64'(fire_t[7]), 64'(ld + 16));
    chk("R9 caught up", 64'(expiry_time_o), 64'(ld + 18));
  endtask

  task automatic t_ignored();
    logic [31:0] c0, l0, e0;
    logic [15:0] n0;
    logic [2:0]  s0;
    logic [3:0]  d0;
    wr(2'd0, vreg(1, 0, 8'h00));
    c0 = tmr_ctrl_o; l0 = load_time_o; e0 = expiry_time_o;
    n0 = initial_count_o; s0 = prescale_shift_o; d0 = divide_cfg_o;
    wr(2'd3, 32'hFFFF_FFFF);
    chk("R11 ctrl", 64'(tmr_ctrl_o), 64'(c0));
    chk("R11 count", 64'(initial_count_o), 64'(n0));
    chk("R11 load", 64'(load_time_o), 64'(l0));
    chk("R11 shift", 64'(prescale_shift_o), 64'(s0));
    chk("R11 divide", 64'(divide_cfg_o), 64'(d0));
    chk("R11 expiry", 64'(expiry_time_o), 64'(e0));
  endtask

  initial begin
    tb_now = 32'd100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_oneshot();
    t_divide();
    t_periodic();
    t_midway();
    t_mask();
    t_catchup();
    t_ignored();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule